// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin general-purpose I/O port. Every pin is set individually to be either a high-impedance input or a driven output, and a small synchronous register interface reaches three registers: one holds the output levels, one holds the pin directions and one is a read-only view of the pin levels. Pin levels pass through a two-flop synchronizer before the block uses them.

Change detection compares the synchronized level of each input pin with a snapshot. The snapshot is taken after reset and again each time the input register is read. The interrupt line is active low and modelled as open drain: it is pulled low while any input pin differs from its snapshot, and released (high-Z) otherwise. It clears by itself when the pins return to the snapshot value. Reading the input register also clears it, because the read replaces the snapshot with the present levels. Pins set as outputs never raise the interrupt. If a pin is switched from output to input while its level differs from the snapshot, the interrupt is raised. This is intended and is not masked.

Register access: assert `req_i` for one clock with `addr_i` and, for a write, `we_i` and `wdata_i`. Read data appears on `rdata_o` after the clock edge that accepts the read, and stays there until the next read.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads 8'hFF, the output register reads 8'hFF, `pin_oe_o` is 8'h00, `rdata_o` is 8'h00 and `int_no` is released.
- R2: A write to address 3 sets the direction register. Bit n controls pin n: 1 means input with the driver off (`pin_oe_o[n]`=0), 0 means output (`pin_oe_o[n]`=1). The value reads back from address 3.
- R3: A write to address 1 sets the output register. It drives `pin_o` after the write edge and reads back from address 1.
- R4: A read of address 0 returns `pin_i` as sampled through the two-flop synchronizer. A level that has been held for two or more clocks is returned unchanged.
- R5: Writes to address 0 and address 2 have no effect on any register or pin. Address 2 reads 8'h00.
- R6: When an input pin changes and holds its new level, `int_no` goes low on the third rising edge after the change: two edges for synchronization and one for the interrupt register.
- R7: A level change on a pin set as an output never pulls `int_no` low.
- R8: When the changed input pins return to their snapshot levels, `int_no` is released on the third rising edge after the return.
- R9: A read of address 0 releases `int_no` at the edge that accepts the read and stores the present levels as the new snapshot, so the pins' current state no longer raises the interrupt.
- R10: Writing the direction register to switch a pin from output to input, while that pin's synchronized level differs from the snapshot, pulls `int_no` low on the edge after the write edge.
- R11: Pin levels that are held steady through and after reset are captured as the first snapshot and do not raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one clock per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address: 0 input, 1 output, 2 unused, 3 direction |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 8 | Pad input levels, asynchronous |
| pin_o | output | 8 | Output register value sent to the pads |
| pin_oe_o | output | 8 | Pad output enable, 1 = drive |
| int_no | output | 1 | Interrupt, open drain, low = asserted, high-Z = released |

## Verification
Change detection is tested with several patterns. A single input pin toggles and then returns to its old level, which separates self-clearing from clearing by a read. A multi-pin change is cleared by reading the input register while the pins keep their new levels, which shows that the read refreshes the snapshot. A toggle on a pin set as an output confirms that the direction mask works. Pin levels held through reset show that the first snapshot is taken correctly. Switching a pin from output to input with a mismatched level confirms that the resulting interrupt is kept.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN   = 2'd0,
    REG_OUT  = 2'd1,
    REG_RSVD = 2'd2,
    REG_DIR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_chg_pkg::*;
#(
  parameter int unsigned WIDTH   = PORT_W,
  parameter logic [WIDTH-1:0] OUT_RST = '1,
  parameter logic [WIDTH-1:0] DIR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  in_sync_i,
  output logic [WIDTH-1:0]  out_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] out_q, dir_q, rdata_q, rd_mux;
  reg_addr_e        sel;

  assign sel = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= OUT_RST;
      dir_q <= DIR_RST;
    end else if (wr_i) begin
      // input and unused addresses drop writes
      if (sel == REG_OUT) out_q <= wdata_i;
      if (sel == REG_DIR) dir_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      REG_IN:  rd_mux = in_sync_i;
      REG_OUT: rd_mux = out_q;
      REG_DIR: rd_mux = dir_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_sync_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             snap_ld_i,
  output logic             irq_o
);
  localparam int unsigned FILL_MAX = SYNC_STAGES + 1;
  localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

  logic [FILL_W-1:0] fill_q;
  logic              armed;
  logic [WIDTH-1:0]  snap_q, diff;
  logic              irq_q;

  assign armed = (fill_q == FILL_W'(FILL_MAX));

  // keep sampling until the synchronizer holds real pin levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fill_q <= '0;
    else if (!armed) fill_q <= fill_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   snap_q <= '0;
    else if (!armed || snap_ld_i)  snap_q <= in_sync_i;
  end

  assign diff = (in_sync_i ^ snap_q) & dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  irq_q <= 1'b0;
    else if (!armed || snap_ld_i) irq_q <= 1'b0;
    else                          irq_q <= |diff;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int unsigned WIDTH       = PORT_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] OUT_RST = '1,
  parameter logic [WIDTH-1:0] DIR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output wire               int_no
);
  logic             wr, rd, rd_in;
  logic [WIDTH-1:0] in_sync, out_q, dir_q;
  logic             irq_q;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign rd_in = rd & (addr_i == REG_IN);

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH), .OUT_RST(OUT_RST), .DIR_RST(DIR_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .rd_i     (rd),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .in_sync_i(in_sync),
    .out_o    (out_q),
    .dir_o    (dir_q),
    .rdata_o  (rdata_o)
  );

  gpio_chg_detect #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_sync_i(in_sync),
    .dir_i    (dir_q),
    .snap_ld_i(rd_in),
    .irq_o    (irq_q)
  );

  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;
  assign int_no   = irq_q ? 1'b0 : 1'bz;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic             irq_q
);
  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd3) |=> (pin_oe_o == ~$past(wdata_i)));

  a_r3_out_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 2'd1) |=> (pin_o == $past(wdata_i)));

  a_r5_dead_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[0] == 1'b0) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  a_r7_outputs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pin_oe_o) == '1) |-> !irq_q);

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 2'd0) |=> !irq_q);
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_q   (irq_q)
);

// File: tb/sim_gpio_chg_port.sv
module sim_gpio_chg_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pin_i = '0;
  logic [7:0] pin_o;
  logic [7:0] pin_oe_o;
  wire        int_no;

  pullup (int_no);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_chg_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .int_no(int_no)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic do_reset(input logic [7:0] pins);
    rst_ni = 1'b0; req_i = 1'b0; pin_i = pins;
    tick(2);
    rst_ni = 1'b1;
    tick(5);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_ni = 1'b0; pin_i = 8'h00;
    tick(2);
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 oe", pin_oe_o, 8'h00);
    chk("R1 int", {7'd0, int_no}, 8'h01);
    rst_ni = 1'b1;
    tick(5);
    rd(2'd3, d); chk("R1 dir", d, 8'hFF);
    rd(2'd1, d); chk("R1 out", d, 8'hFF);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(2'd3, 8'h3C);
    chk("R2 oe", pin_oe_o, 8'hC3);
    rd(2'd3, d); chk("R2 readback", d, 8'h3C);
    wr(2'd1, 8'h96);
    chk("R3 pin_o", pin_o, 8'h96);
    rd(2'd1, d); chk("R3 readback", d, 8'h96);
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h22);
    chk("R5 pin_o", pin_o, 8'h96);
    chk("R5 oe", pin_oe_o, 8'hC3);
    rd(2'd2, d); chk("R5 rsvd read", d, 8'h00);
    rd(2'd1, d); chk("R5 out kept", d, 8'h96);
    rd(2'd3, d); chk("R5 dir kept", d, 8'h3C);
    wr(2'd3, 8'hFF);
  endtask

  task automatic t_input_read();
    logic [7:0] d;
    do_reset(8'h00);
    pin_i = 8'h5A;
    tick(3);
    rd(2'd0, d); chk("R4 input", d, 8'h5A);
  endtask

  task automatic t_toggle_revert();
    do_reset(8'h00);
    @(negedge clk_i); pin_i = 8'h10;
    tick(2); chk("R6 not yet", {7'd0, int_no}, 8'h01);
    tick(1); chk("R6 asserted", {7'd0, int_no}, 8'h00);
    pin_i = 8'h00;
    tick(2); chk("R8 still low", {7'd0, int_no}, 8'h00);
    tick(1); chk("R8 released", {7'd0, int_no}, 8'h01);
  endtask

  task automatic t_read_clear();
    logic [7:0] d;
    do_reset(8'h00);
    @(negedge clk_i); pin_i = 8'hC1;
    tick(3); chk("R6 multi", {7'd0, int_no}, 8'h00);
    rd(2'd0, d);
    chk("R9 released", {7'd0, int_no}, 8'h01);
    chk("R9 data", d, 8'hC1);
    tick(4); chk("R9 stays", {7'd0, int_no}, 8'h01);
    pin_i = 8'h00;
    tick(3); chk("R9 new snapshot", {7'd0, int_no}, 8'h00);
  endtask

  task automatic t_dir_switch();
    logic [7:0] d;
    do_reset(8'h00);
    wr(2'd3, 8'hFE);
    @(negedge clk_i); pin_i = 8'h01;
    tick(5); chk("R7 masked", {7'd0, int_no}, 8'h01);
    wr(2'd3, 8'hFF);
    chk("R10 pre", {7'd0, int_no}, 8'h01);
    tick(1); chk("R10 raised", {7'd0, int_no}, 8'h00);
    rd(2'd0, d);
  endtask

  task automatic t_reset_capture();
    logic [7:0] d;
    do_reset(8'hA5);
    tick(4); chk("R11 quiet", {7'd0, int_no}, 8'h01);
    rd(2'd0, d); chk("R11 level", d, 8'hA5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_input_read();
    t_toggle_revert();
    t_read_clear();
    t_dir_switch();
    t_reset_capture();
    finish_run();
  end
endmodule